// File: doc/BRIEF.md
# Platform Power State Sequencer

This block walks a host platform between its fully-off, standby, suspend-to-RAM and running states. It owns the enables of five regulators (suspend supply, memory rail, 5 V rail, 3.3 V rail, core regulator), the active-low resume reset, the system and core power-good indications and the host throttle line. It watches three power-good inputs and two active-high "stay awake" requests from the host. A restartable millisecond timer sets every dwell time and every power-good timeout. The number of clocks in one millisecond is a parameter.

The power-up order runs suspend supply, resume-reset release, memory rail, 5 V, 3.3 V, core, throttle and then power-good. The power-down order is different: power-good falls first, then core and throttle after a short gap, then 3.3 V, and 5 V last. Each wait for a power-good has its own timeout and its own failure path. Losing a required rail while in suspend or running forces a shutdown. The shutdown pulls system power-good low and asserts the resume reset on the same clock edge. It then drains the platform down to fully-off.

Top module: `plat_pwr_seq`

## Requirements
- R1: During and right after reset, every enable is low, resume_rst_n is low, both power-good outputs and throttle are low, and state is 0.
- R2: In the off state (0), wake_req high starts a 10 ms wait (state 1) with sus_en low. sus_en then rises and the block waits for pg_sus (state 2). If pg_sus is still low when the timeout expires, sus_en falls and state returns to 0.
- R3: When pg_sus is seen in state 2, resume_rst_n goes high. After a 10 ms settle (state 3) the block enters standby (state 4).
- R4: In standby, host_hold high starts the path to suspend. The block waits for pg_sus (state 5), then raises mem_en and waits for pg_mem (state 6), then enters suspend (state 7). A timeout in state 5 or 6 returns to state 0 with every enable off and resume_rst_n low.
- R5: In suspend, host_run high raises rail5_en and holds for 3 ms (state 8). It then raises rail3_en and waits for pg_noncore (state 9). A timeout drops both rails, asserts a shutdown and returns to state 7.
- R6: Once pg_noncore is seen, core_en rises and holds for 15 ms (state 10). Then throttle takes the value of throttle_req for one cycle (state 11) before sys_pwr_ok and core_pwr_ok both rise (state 12). While running, throttle follows throttle_req.
- R7: While running, host_run low drops both power-good outputs at once (state 13). core_en and throttle fall GAP_CYC cycles later (state 14). rail3_en falls 7 ms after that (state 15). rail5_en falls on the next cycle as the block re-enters state 7 with resume_rst_n still high.
- R8: In suspend with rails good and no shutdown pending, host_hold low turns off rail5_en and mem_en and enters standby. The block stays in standby with sus_en and resume_rst_n high.
- R9: While running, a low pg_sus, pg_mem or pg_noncore pulls sys_pwr_ok, core_pwr_ok and resume_rst_n low on the next edge, and the power-down path of R7 follows.
- R10: In suspend, a low pg_sus or pg_mem, or a pending shutdown (resume_rst_n low), moves to standby on the next edge with mem_en and rail5_en off. Rail loss takes priority over host_run high.
- R11: In standby with resume_rst_n low, the block moves to state 0 on the next edge with sus_en low.
- R12: Each timed step lasts N*CLKS_PER_MS+1 cycles, where N is its millisecond count. A power-good timeout fires PG_TIMEOUT_MS*CLKS_PER_MS+1 cycles after the wait state is entered (100 ms by default). State codes: 0 off, 1 pre-suspend wait, 2 suspend-good wait, 3 clock settle, 4 standby, 5 always-on wait, 6 memory-good wait, 7 suspend, 8 5 V dwell, 9 non-core-good wait, 10 core settle, 11 throttle setup, 12 running, 13 power-good drop, 14 rail drain, 15 3.3 V off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_req | input | 1 | Request to leave the off state |
| host_run | input | 1 | Host requests running (low asks to sleep to suspend) |
| host_hold | input | 1 | Host requests suspend or above (low asks to drop to standby) |
| pg_sus | input | 1 | Suspend / always-on rail good |
| pg_mem | input | 1 | Memory rail good |
| pg_noncore | input | 1 | 5 V and 3.3 V rails good |
| throttle_req | input | 1 | Requested throttle level |
| sus_en | output | 1 | Suspend regulator enable |
| mem_en | output | 1 | Memory rail enable |
| rail5_en | output | 1 | 5 V rail enable |
| rail3_en | output | 1 | 3.3 V rail enable |
| core_en | output | 1 | Core regulator enable |
| resume_rst_n | output | 1 | Active-low resume reset |
| sys_pwr_ok | output | 1 | System power-good |
| core_pwr_ok | output | 1 | Core power-good |
| throttle | output | 1 | Host throttle |
| state | output | 4 | Encoded sequencer state |

## Verification
Two pairs of events can land on the same edge: rail loss with a sleep request while running, and rail loss with a run request while in suspend. The bench changes both inputs of a pair at one falling edge. While running, the result must be the power-down path with resume_rst_n also forced low. That is the shutdown variant, not the plain sleep variant. In suspend, the move must be to standby with the 5 V rail untouched, not to the 5 V dwell.

// File: rtl/plat_pwr_pkg.sv
package plat_pwr_pkg;

    typedef enum logic [3:0] {
        ST_OFF        = 4'd0,
        ST_PRE_SUS    = 4'd1,
        ST_SUS_GOOD   = 4'd2,
        ST_CLK_SETTLE = 4'd3,
        ST_STANDBY    = 4'd4,
        ST_AON_WAIT   = 4'd5,
        ST_MEM_GOOD   = 4'd6,
        ST_SUSPEND    = 4'd7,
        ST_R5_DWELL   = 4'd8,
        ST_NC_GOOD    = 4'd9,
        ST_CORE_SET   = 4'd10,
        ST_THR_SETUP  = 4'd11,
        ST_RUN        = 4'd12,
        ST_PG_DROP    = 4'd13,
        ST_DRAIN      = 4'd14,
        ST_R3_OFF     = 4'd15
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       sus;
        logic       mem;
        logic       r5;
        logic       r3;
        logic       core;
        logic       rsm_n;
        logic       sys_ok;
        logic       core_ok;
        logic       thr;
    } seq_regs_t;

endpackage

// File: rtl/pwr_prescale.sv
module pwr_prescale #(
    parameter int CLKS_PER_MS = 32768
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart_i,
    output logic [CYC_W-1:0]      cyc_o,
    output logic                  tick_o
);
    localparam int CYC_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [CYC_W-1:0] LAST = CYC_W'(CLKS_PER_MS - 1);

    logic [CYC_W-1:0] cyc_d, cyc_q;

    always_comb begin
        if (restart_i)          cyc_d = '0;
        else if (cyc_q == LAST) cyc_d = '0;
        else                    cyc_d = cyc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_d;
    end

    assign cyc_o  = cyc_q;
    assign tick_o = !restart_i && (cyc_q == LAST);

    // R12: the cycle count never passes the end of a millisecond
    a_r12_cyc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q <= LAST);

endmodule

// File: rtl/pwr_ms_count.sv
module pwr_ms_count #(
    parameter int MS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart_i,
    input  logic            tick_i,
    output logic [MS_W-1:0] ms_o
);
    logic [MS_W-1:0] ms_d, ms_q;

    always_comb begin
        ms_d = ms_q;
        if (restart_i)                  ms_d = '0;
        else if (tick_i && ~&ms_q)      ms_d = ms_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ms_q <= '0;
        else        ms_q <= ms_d;
    end

    assign ms_o = ms_q;

    // R12: elapsed time only grows until the next restart
    a_r12_ms_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> (ms_q >= $past(ms_q)));

endmodule

// File: rtl/plat_pwr_seq.sv
module plat_pwr_seq
    import plat_pwr_pkg::*;
#(
    parameter int CLKS_PER_MS   = 32768,
    parameter int T_PRE_SUS_MS  = 10,
    parameter int T_CLK_MS      = 10,
    parameter int T_R5_MS       = 3,
    parameter int T_CORE_MS     = 15,
    parameter int T_DRAIN_MS    = 7,
    parameter int PG_TIMEOUT_MS = 100,
    parameter int GAP_CYC       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_req,
    input  logic       host_run,
    input  logic       host_hold,
    input  logic       pg_sus,
    input  logic       pg_mem,
    input  logic       pg_noncore,
    input  logic       throttle_req,
    output logic       sus_en,
    output logic       mem_en,
    output logic       rail5_en,
    output logic       rail3_en,
    output logic       core_en,
    output logic       resume_rst_n,
    output logic       sys_pwr_ok,
    output logic       core_pwr_ok,
    output logic       throttle,
    output logic [3:0] state
);
    localparam int CYC_W  = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam int M1     = (T_PRE_SUS_MS > T_CLK_MS) ? T_PRE_SUS_MS : T_CLK_MS;
    localparam int M2     = (M1 > T_R5_MS) ? M1 : T_R5_MS;
    localparam int M3     = (M2 > T_CORE_MS) ? M2 : T_CORE_MS;
    localparam int M4     = (M3 > T_DRAIN_MS) ? M3 : T_DRAIN_MS;
    localparam int MS_MAX = (M4 > PG_TIMEOUT_MS) ? M4 : PG_TIMEOUT_MS;
    localparam int MS_W   = $clog2(MS_MAX + 2);

    localparam logic [MS_W-1:0]  K_PRE   = MS_W'(T_PRE_SUS_MS);
    localparam logic [MS_W-1:0]  K_CLK   = MS_W'(T_CLK_MS);
    localparam logic [MS_W-1:0]  K_R5    = MS_W'(T_R5_MS);
    localparam logic [MS_W-1:0]  K_CORE  = MS_W'(T_CORE_MS);
    localparam logic [MS_W-1:0]  K_DRAIN = MS_W'(T_DRAIN_MS);
    localparam logic [MS_W-1:0]  K_TO    = MS_W'(PG_TIMEOUT_MS);
    localparam logic [CYC_W-1:0] K_GAP   = CYC_W'(GAP_CYC - 1);

    seq_regs_t        cur_q, nx_d;
    logic             restart;
    logic             tick;
    logic [CYC_W-1:0] cyc;
    logic [MS_W-1:0]  ms;
    logic             s3_good, s0_good;

    assign s3_good = pg_sus && pg_mem;
    assign s0_good = s3_good && pg_noncore;
    assign restart = (nx_d.st != cur_q.st);

    pwr_prescale #(.CLKS_PER_MS(CLKS_PER_MS)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .cyc_o(cyc), .tick_o(tick)
    );

    pwr_ms_count #(.MS_W(MS_W)) u_ms (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .tick_i(tick), .ms_o(ms)
    );

    always_comb begin
        nx_d = cur_q;
        unique case (cur_q.st)
            ST_OFF: if (wake_req) nx_d.st = ST_PRE_SUS;
            ST_PRE_SUS: if (ms == K_PRE) begin
                nx_d.sus = 1'b1;
                nx_d.st  = ST_SUS_GOOD;
            end
            ST_SUS_GOOD: begin
                if (pg_sus) begin
                    nx_d.rsm_n = 1'b1;
                    nx_d.st    = ST_CLK_SETTLE;
                end else if (ms == K_TO) begin
                    nx_d.sus    = 1'b0;
                    nx_d.sys_ok = 1'b0;
                    nx_d.rsm_n  = 1'b0;
                    nx_d.st     = ST_OFF;
                end
            end
            ST_CLK_SETTLE: if (ms == K_CLK) nx_d.st = ST_STANDBY;
            ST_STANDBY: begin
                if (!cur_q.rsm_n) begin
                    nx_d.sus = 1'b0;
                    nx_d.st  = ST_OFF;
                end else if (host_hold) begin
                    nx_d.st = ST_AON_WAIT;
                end
            end
            ST_AON_WAIT, ST_MEM_GOOD: begin
                if ((cur_q.st == ST_AON_WAIT) ? pg_sus : pg_mem) begin
                    nx_d.mem = 1'b1;
                    nx_d.st  = (cur_q.st == ST_AON_WAIT) ? ST_MEM_GOOD : ST_SUSPEND;
                end else if (ms == K_TO) begin
                    nx_d.mem    = 1'b0;
                    nx_d.sus    = 1'b0;
                    nx_d.sys_ok = 1'b0;
                    nx_d.rsm_n  = 1'b0;
                    nx_d.st     = ST_OFF;
                end
            end
            ST_SUSPEND: begin
                if (!s3_good || !cur_q.rsm_n) begin
                    nx_d.sys_ok = 1'b0;
                    nx_d.rsm_n  = 1'b0;
                    nx_d.r5     = 1'b0;
                    nx_d.mem    = 1'b0;
                    nx_d.st     = ST_STANDBY;
                end else if (host_run) begin
                    nx_d.r5 = 1'b1;
                    nx_d.st = ST_R5_DWELL;
                end else if (!host_hold) begin
                    nx_d.r5  = 1'b0;
                    nx_d.mem = 1'b0;
                    nx_d.st  = ST_STANDBY;
                end
            end
            ST_R5_DWELL: if (ms == K_R5) begin
                nx_d.r3 = 1'b1;
                nx_d.st = ST_NC_GOOD;
            end
            ST_NC_GOOD: begin
                if (pg_noncore) begin
                    nx_d.core = 1'b1;
                    nx_d.st   = ST_CORE_SET;
                end else if (ms == K_TO) begin
                    nx_d.r3     = 1'b0;
                    nx_d.r5     = 1'b0;
                    nx_d.sys_ok = 1'b0;
                    nx_d.rsm_n  = 1'b0;
                    nx_d.st     = ST_SUSPEND;
                end
            end
            ST_CORE_SET: if (ms == K_CORE) begin
                nx_d.thr = throttle_req;
                nx_d.st  = ST_THR_SETUP;
            end
            ST_THR_SETUP: begin
                nx_d.sys_ok  = 1'b1;
                nx_d.core_ok = 1'b1;
                nx_d.st      = ST_RUN;
            end
            ST_RUN: begin
                nx_d.thr = throttle_req;
                if (!s0_good) begin
                    nx_d.sys_ok  = 1'b0;
                    nx_d.core_ok = 1'b0;
                    nx_d.rsm_n   = 1'b0;
                    nx_d.st      = ST_PG_DROP;
                end else if (!host_run) begin
                    nx_d.sys_ok  = 1'b0;
                    nx_d.core_ok = 1'b0;
                    nx_d.st      = ST_PG_DROP;
                end
            end
            ST_PG_DROP: if (cyc == K_GAP) begin
                nx_d.core = 1'b0;
                nx_d.thr  = 1'b0;
                nx_d.st   = ST_DRAIN;
            end
            ST_DRAIN: if (ms == K_DRAIN) begin
                nx_d.r3 = 1'b0;
                nx_d.st = ST_R3_OFF;
            end
            ST_R3_OFF: begin
                nx_d.r5 = 1'b0;
                nx_d.st = ST_SUSPEND;
            end
            default: nx_d = cur_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_OFF, default: 1'b0};
        else        cur_q <= nx_d;
    end

    assign sus_en       = cur_q.sus;
    assign mem_en       = cur_q.mem;
    assign rail5_en     = cur_q.r5;
    assign rail3_en     = cur_q.r3;
    assign core_en      = cur_q.core;
    assign resume_rst_n = cur_q.rsm_n;
    assign sys_pwr_ok   = cur_q.sys_ok;
    assign core_pwr_ok  = cur_q.core_ok;
    assign throttle     = cur_q.thr;
    assign state        = cur_q.st;

    // R6: power-good only with core and both non-core rails enabled
    a_r6_pwrok_needs_rails: assert property (@(posedge clk) disable iff (!rst_n)
        sys_pwr_ok |-> (core_en && rail3_en && rail5_en));

    // R6: core power-good rises only after the core has been on
    a_r6_core_before_ok: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_pwr_ok) |-> $past(core_en));

    // R7: core regulator falls only after power-good is already gone
    a_r7_core_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_en) |-> (!core_pwr_ok && $past(!core_pwr_ok)));

    // R7: 5 V is never removed while 3.3 V is still on
    a_r7_r5_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail5_en) |-> !rail3_en);

    // R3: resume reset released only with the suspend supply on
    a_r3_rsm_needs_sus: assert property (@(posedge clk) disable iff (!rst_n)
        resume_rst_n |-> sus_en);

    // R4: memory rail only with the suspend supply on
    a_r4_mem_needs_sus: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> sus_en);

    // R9: rail loss while running forces shutdown on the next edge
    a_r9_loss_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !(pg_sus && pg_mem && pg_noncore))
            |=> (!sys_pwr_ok && !core_pwr_ok && !resume_rst_n));

endmodule

// File: tb/tb_plat_pwr_seq.sv
module tb_plat_pwr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 10;

    localparam logic [3:0] S_OFF = 4'd0, S_PRE = 4'd1, S_SGOOD = 4'd2,
        S_CLK = 4'd3, S_STBY = 4'd4, S_AON = 4'd5, S_MEM = 4'd6,
        S_SUSP = 4'd7, S_R5 = 4'd8, S_NC = 4'd9, S_CORE = 4'd10,
        S_THR = 4'd11, S_RUN = 4'd12, S_DROP = 4'd13, S_DRAIN = 4'd14,
        S_R3OFF = 4'd15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake_req = 1'b0, host_run = 1'b0, host_hold = 1'b0;
    logic pg_sus = 1'b0, pg_mem = 1'b0, pg_noncore = 1'b0, throttle_req = 1'b0;
    logic sus_en, mem_en, rail5_en, rail3_en, core_en, resume_rst_n;
    logic sys_pwr_ok, core_pwr_ok, throttle;
    logic [3:0] state;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plat_pwr_seq #(.CLKS_PER_MS(CPM)) dut (
        .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .host_run(host_run),
        .host_hold(host_hold), .pg_sus(pg_sus), .pg_mem(pg_mem),
        .pg_noncore(pg_noncore), .throttle_req(throttle_req),
        .sus_en(sus_en), .mem_en(mem_en), .rail5_en(rail5_en),
        .rail3_en(rail3_en), .core_en(core_en), .resume_rst_n(resume_rst_n),
        .sys_pwr_ok(sys_pwr_ok), .core_pwr_ok(core_pwr_ok),
        .throttle(throttle), .state(state)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic goto_state(input logic [3:0] s, input string req);
        int n = 0;
        while (state !== s && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(req, int'(state), int'(s));
    endtask

    task automatic dwell(input logic [3:0] s, input int exp, input string req);
        int n = 0;
        while (state === s && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check(req, n, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 outputs in reset", int'({sus_en, mem_en, rail5_en, rail3_en, core_en,
              resume_rst_n, sys_pwr_ok, core_pwr_ok, throttle}), 0);
        check("R1 state in reset", int'(state), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 state after reset", int'(state), 0);
        check("R1 resume reset after reset", int'(resume_rst_n), 0);
    endtask

    task automatic t_sus_timeout();
        pg_sus = 1'b0;
        wake_req = 1'b1;
        goto_state(S_PRE, "R2 leave off");
        check("R2 sus off during wait", int'(sus_en), 0);
        dwell(S_PRE, 10*CPM+1, "R12 pre-suspend dwell");
        check("R2 sus on", int'(sus_en), 1);
        dwell(S_SGOOD, 100*CPM+1, "R12 suspend-good timeout");
        wake_req = 1'b0;
        check("R2 back to off", int'(state), int'(S_OFF));
        check("R2 sus off after fail", int'(sus_en), 0);
        check("R2 reset held", int'(resume_rst_n), 0);
    endtask

    task automatic t_up_standby();
        pg_sus = 1'b1;
        wake_req = 1'b1;
        goto_state(S_PRE, "R2 leave off again");
        dwell(S_PRE, 10*CPM+1, "R12 pre-suspend dwell");
        check("R3 reset held before good", int'(resume_rst_n), 0);
        dwell(S_SGOOD, 1, "R3 suspend good seen");
        check("R3 reset released", int'(resume_rst_n), 1);
        dwell(S_CLK, 10*CPM+1, "R3 clock settle dwell");
        wake_req = 1'b0;
        check("R3 standby", int'(state), int'(S_STBY));
    endtask

    task automatic t_standby_suspend();
        pg_mem = 1'b1;
        host_hold = 1'b1;
        goto_state(S_AON, "R4 always-on wait");
        check("R4 mem off before aon", int'(mem_en), 0);
        dwell(S_AON, 1, "R4 aon dwell");
        check("R4 mem on", int'(mem_en), 1);
        dwell(S_MEM, 1, "R4 mem good dwell");
        check("R4 suspend reached", int'(state), int'(S_SUSP));
    endtask

    task automatic t_suspend_run();
        pg_noncore = 1'b1;
        throttle_req = 1'b1;
        host_run = 1'b1;
        goto_state(S_R5, "R5 5V dwell");
        check("R5 5V on, 3V3 off", int'({rail5_en, rail3_en}), 2);
        dwell(S_R5, 3*CPM+1, "R5 5V dwell length");
        check("R5 3V3 on, core off", int'({rail3_en, core_en}), 2);
        dwell(S_NC, 1, "R5 non-core good dwell");
        check("R6 core on", int'(core_en), 1);
        dwell(S_CORE, 15*CPM+1, "R6 core settle length");
        check("R6 throttle before ok", int'({throttle, sys_pwr_ok, core_pwr_ok}), 4);
        dwell(S_THR, 1, "R6 throttle setup dwell");
        check("R6 both ok high", int'({sys_pwr_ok, core_pwr_ok}), 3);
        check("R6 running", int'(state), int'(S_RUN));
        throttle_req = 1'b0;
        @(negedge clk);
        check("R6 throttle follows", int'(throttle), 0);
        throttle_req = 1'b1;
        @(negedge clk);
        check("R6 throttle follows high", int'(throttle), 1);
    endtask

    task automatic t_run_suspend();
        host_run = 1'b0;
        goto_state(S_DROP, "R7 pg drop");
        check("R7 ok low, core still on", int'({sys_pwr_ok, core_pwr_ok, core_en}), 1);
        dwell(S_DROP, 2, "R7 gap before core off");
        check("R7 core and throttle off", int'({core_en, throttle}), 0);
        check("R7 3V3 still on", int'(rail3_en), 1);
        dwell(S_DRAIN, 7*CPM+1, "R7 drain length");
        check("R7 3V3 off, 5V on", int'({rail3_en, rail5_en}), 1);
        dwell(S_R3OFF, 1, "R7 3V3-off dwell");
        check("R7 back in suspend", int'(state), int'(S_SUSP));
        check("R7 5V off, reset released", int'({rail5_en, resume_rst_n}), 1);
    endtask

    task automatic t_suspend_standby();
        host_hold = 1'b0;
        goto_state(S_STBY, "R8 standby");
        check("R8 mem and 5V off", int'({mem_en, rail5_en}), 0);
        repeat (20) @(negedge clk);
        check("R8 stays in standby", int'(state), int'(S_STBY));
        check("R8 sus on, reset released", int'({sus_en, resume_rst_n}), 3);
    endtask

    task automatic t_priority_suspend();
        host_hold = 1'b1;
        goto_state(S_SUSP, "R10 suspend again");
        host_run = 1'b1;
        pg_mem = 1'b0;
        @(negedge clk);
        check("R10 rail loss beats run", int'(state), int'(S_STBY));
        check("R10 5V mem off, reset low", int'({rail5_en, mem_en, resume_rst_n}), 0);
        @(negedge clk);
        check("R11 off after pending shutdown", int'(state), int'(S_OFF));
        check("R11 sus off", int'(sus_en), 0);
        host_run = 1'b0;
        pg_mem = 1'b1;
    endtask

    task automatic t_noncore_timeout();
        wake_req = 1'b1;
        goto_state(S_STBY, "R5 standby");
        wake_req = 1'b0;
        goto_state(S_SUSP, "R5 suspend");
        pg_noncore = 1'b0;
        host_run = 1'b1;
        goto_state(S_NC, "R5 non-core wait");
        dwell(S_NC, 100*CPM+1, "R12 non-core timeout");
        check("R5 back to suspend", int'(state), int'(S_SUSP));
        check("R5 rails off, reset low", int'({rail5_en, rail3_en, resume_rst_n}), 0);
        @(negedge clk);
        check("R10 pending shutdown to standby", int'(state), int'(S_STBY));
        @(negedge clk);
        check("R11 to off", int'(state), int'(S_OFF));
        host_run = 1'b0;
    endtask

    task automatic t_loss_in_run();
        pg_noncore = 1'b1;
        host_run = 1'b1;
        wake_req = 1'b1;
        goto_state(S_RUN, "R9 running");
        wake_req = 1'b0;
        pg_noncore = 1'b0;
        host_run = 1'b0;
        @(negedge clk);
        check("R9 pg drop state", int'(state), int'(S_DROP));
        check("R9 ok and reset low, core on",
              int'({sys_pwr_ok, core_pwr_ok, resume_rst_n, core_en}), 1);
        goto_state(S_OFF, "R9 ends in off");
        check("R9 everything off", int'({sus_en, mem_en, rail5_en, rail3_en, core_en}), 0);
    endtask

    initial begin
        t_reset();
        t_sus_timeout();
        t_up_standby();
        t_standby_suspend();
        t_suspend_run();
        t_run_suspend();
        t_suspend_standby();
        t_priority_suspend();
        t_noncore_timeout();
        t_loss_in_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R12 watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule